// File: doc/BRIEF.md
# Interrupt Arbitration Unit

This unit gathers interrupt requests from peripherals into a set of pending flags, one per vector, and at each instruction boundary decides whether the core is diverted to a handler. The core signals the end of every instruction step with a strobe. On that strobe the unit picks the pending vector with the lowest index among those allowed to compete. While the core runs, every pending vector competes. While it sleeps, only vectors whose wake capability matches the current sleep-mode code compete.

A chosen vector with index zero is the reset vector. It makes the unit request a full core reset and empty the pending set. Any other chosen vector is serviced only when the global interrupt-enable flag is set. Servicing issues a stack push of the current PC (two or three bytes), a strobe that clears the enable flag, and a new PC equal to the vector index plus a vector-table offset. The serviced vector is then dropped from the pending set. If the step just completed was a return from interrupt, no check is made on that boundary, so the core always runs one more instruction before the next handler is entered.

All service outputs are registered. They appear one clock after the clock edge that samples the step strobe.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, take_o, push_o, gie_clr_o and core_rst_o are low and no vector is pending.
- R2: A bit set in raise_i makes that vector pending from the next edge. Raising a vector that is already pending still leaves a single request, which is serviced once.
- R3: A bit set in clear_i removes exactly that vector from the pending set. When raise_i and clear_i name the same vector in the same cycle, the vector stays pending.
- R4: When several vectors are eligible, the one with the lowest index is chosen.
- R5: While sleeping_i is 1, vector i is eligible only if wake_cap_i[i*8 +: 8] AND sleep_mode_i is nonzero. While sleeping_i is 0, every pending vector is eligible.
- R6: If the chosen vector is index 0, core_rst_o pulses for one cycle after the step edge. No take happens, and the whole pending set is emptied, including raises in that same cycle.
- R7: If the chosen vector is nonzero and gie_i is 1, then in the cycle after the step edge take_o, push_o and gie_clr_o are 1. new_pc_o equals (vec_offset_i + index) modulo 2^PC_W, push_pc_o equals the sampled pc_i, and push_nbytes_o is 3 when pc3_i is 1 and 2 otherwise. The vector leaves the pending set unless it is raised again in that cycle.
- R8: If the chosen vector is nonzero and gie_i is 0, no output pulses and the request stays pending.
- R9: A step strobe with reti_i set performs no check: nothing pulses after it and the pending set is kept.
- R10: Without step_done_i, no vector is chosen and no output pulses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raise_i | input | NVEC | Per-vector request strobes |
| clear_i | input | NVEC | Per-vector withdraw strobes |
| gie_i | input | 1 | Global interrupt-enable flag |
| sleeping_i | input | 1 | 1 while the core sleeps |
| sleep_mode_i | input | MODE_W | Current sleep-mode code |
| wake_cap_i | input | NVEC*MODE_W | Wake-capability field per vector, vector i at bits i*MODE_W upward |
| step_done_i | input | 1 | Instruction step complete |
| reti_i | input | 1 | The completed step was a return from interrupt |
| pc_i | input | PC_W | Current program counter |
| vec_offset_i | input | PC_W | Vector-table base offset |
| pc3_i | input | 1 | Push three PC bytes instead of two |
| take_o | output | 1 | Vector taken pulse |
| new_pc_o | output | PC_W | Handler address, valid with take_o |
| push_o | output | 1 | Stack push request |
| push_pc_o | output | PC_W | Return address to push |
| push_nbytes_o | output | 2 | Byte count of the push (2 or 3) |
| gie_clr_o | output | 1 | Clear the global enable flag |
| core_rst_o | output | 1 | Request a full core reset |

## Verification
Pending state is visible only through service. A lost, stuck or misplaced pending flag shows up on the next step edge that permits a check. It appears one clock later as a missing take, an extra take, or a take with the wrong new_pc_o. A wrong wake filter or wrong priority shows in the same way, as a handler address from an unexpected vector. A late or early flush after the reset vector shows as vectors serviced after core_rst_o when none should remain.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_TAKE  = 2'd2,
    ACT_RESET = 2'd3
  } arb_act_e;

  // Byte count of the return-address push.
  function automatic logic [1:0] pc_push_bytes(input logic three);
    return three ? 2'd3 : 2'd2;
  endfunction

endpackage

// File: rtl/irq_pending_set.sv
`timescale 1ns/1ps
module irq_pending_set #(
  parameter int NVEC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] raise_i,
  input  logic [NVEC-1:0] clear_i,
  input  logic [NVEC-1:0] svc_i,
  input  logic            flush_i,
  output logic [NVEC-1:0] pend_o
);

  logic [NVEC-1:0] pend_q;
  logic [NVEC-1:0] pend_d;

  // A raise outranks a clear or a service in the same cycle; a flush outranks all.
  always_comb begin
    if (flush_i) pend_d = '0;
    else         pend_d = (pend_q & ~clear_i & ~svc_i) | raise_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R2
  raise_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|raise_i && !flush_i) |=> ((pend_o & $past(raise_i)) == $past(raise_i)));

  // R3
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clear_i & ~raise_i)) |=> ((pend_o & $past(clear_i & ~raise_i)) == '0));

  // R7
  svc_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_i) |=> ((pend_o & $past(svc_i & ~raise_i)) == '0));

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (pend_o == '0));

endmodule

// File: rtl/irq_wake_filter.sv
`timescale 1ns/1ps
module irq_wake_filter #(
  parameter int NVEC   = 32,
  parameter int MODE_W = 8
) (
  input  logic [NVEC-1:0]        pend_i,
  input  logic                   sleeping_i,
  input  logic [MODE_W-1:0]      mode_i,
  input  logic [NVEC*MODE_W-1:0] wake_cap_i,
  output logic [NVEC-1:0]        elig_o
);

  logic [NVEC-1:0] can_wake;

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    assign can_wake[g] = |(wake_cap_i[g*MODE_W +: MODE_W] & mode_i);
    assign elig_o[g]   = pend_i[g] & (~sleeping_i | can_wake[g]);
  end

  // R5
  always_comb begin
    if (!$isunknown(pend_i) && !$isunknown(elig_o)) begin
      elig_subset_chk: assert ((elig_o & ~pend_i) == '0);
    end
  end

endmodule

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
module irq_prio_pick #(
  parameter int NVEC = 32,
  localparam int VEC_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic [NVEC-1:0]  req_i,
  output logic             any_o,
  output logic [VEC_W-1:0] idx_o,
  output logic [NVEC-1:0]  grant_o
);

  function automatic logic [VEC_W-1:0] lowest_set(input logic [NVEC-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (v[i]) r = VEC_W'(i);
    end
    return r;
  endfunction

  assign any_o   = |req_i;
  assign idx_o   = lowest_set(req_i);
  assign grant_o = req_i & (~req_i + 1'b1);

  // R4
  always_comb begin
    if (any_o === 1'b1) begin
      grant_lowest_chk: assert ((((grant_o - 1'b1) & req_i) == '0) && ((grant_o & req_i) == grant_o));
    end
  end

endmodule

// File: rtl/irq_service_ctl.sv
`timescale 1ns/1ps
module irq_service_ctl
  import irq_arb_pkg::*;
#(
  parameter int NVEC = 32,
  parameter int PC_W = 22,
  localparam int VEC_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             reti_i,
  input  logic             gie_i,
  input  logic             any_i,
  input  logic [VEC_W-1:0] idx_i,
  input  logic [NVEC-1:0]  grant_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  offset_i,
  input  logic             pc3_i,
  output logic [NVEC-1:0]  svc_o,
  output logic             flush_o,
  output logic             take_o,
  output logic [PC_W-1:0]  new_pc_o,
  output logic             push_o,
  output logic [PC_W-1:0]  push_pc_o,
  output logic [1:0]       push_nbytes_o,
  output logic             gie_clr_o,
  output logic             core_rst_o
);

  function automatic logic [PC_W-1:0] vec_target(input logic [PC_W-1:0] base,
                                                 input logic [VEC_W-1:0] idx);
    return base + PC_W'(idx);
  endfunction

  arb_act_e act;
  logic     take_q, rst_q;
  logic [PC_W-1:0] npc_q, ppc_q;
  logic [1:0]      nb_q;

  always_comb begin
    act = ACT_NONE;
    if (step_i && !reti_i && any_i) begin
      if (idx_i == '0)  act = ACT_RESET;
      else if (gie_i)   act = ACT_TAKE;
      else              act = ACT_HOLD;
    end
  end

  assign svc_o   = (act == ACT_TAKE) ? grant_i : '0;
  assign flush_o = (act == ACT_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      rst_q  <= 1'b0;
      npc_q  <= '0;
      ppc_q  <= '0;
      nb_q   <= 2'd2;
    end else begin
      take_q <= (act == ACT_TAKE);
      rst_q  <= (act == ACT_RESET);
      if (act == ACT_TAKE) begin
        npc_q <= vec_target(offset_i, idx_i);
        ppc_q <= pc_i;
        nb_q  <= pc_push_bytes(pc3_i);
      end
    end
  end

  assign take_o        = take_q;
  assign push_o        = take_q;
  assign gie_clr_o     = take_q;
  assign core_rst_o    = rst_q;
  assign new_pc_o      = npc_q;
  assign push_pc_o     = ppc_q;
  assign push_nbytes_o = nb_q;

  // R7
  take_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !reti_i && any_i && gie_i && (idx_i != '0) |=> take_o && push_o && gie_clr_o);

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !gie_i) |=> !take_o);

  // R9
  reti_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && reti_i) |=> (!take_o && !core_rst_o));

  // R10
  no_step_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> (!take_o && !core_rst_o));

  // R6
  rst_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> !take_o);

endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter #(
  parameter int NVEC   = 32,
  parameter int MODE_W = 8,
  parameter int PC_W   = 22,
  localparam int VEC_W = (NVEC > 1) ? $clog2(NVEC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NVEC-1:0]        raise_i,
  input  logic [NVEC-1:0]        clear_i,
  input  logic                   gie_i,
  input  logic                   sleeping_i,
  input  logic [MODE_W-1:0]      sleep_mode_i,
  input  logic [NVEC*MODE_W-1:0] wake_cap_i,
  input  logic                   step_done_i,
  input  logic                   reti_i,
  input  logic [PC_W-1:0]        pc_i,
  input  logic [PC_W-1:0]        vec_offset_i,
  input  logic                   pc3_i,
  output logic                   take_o,
  output logic [PC_W-1:0]        new_pc_o,
  output logic                   push_o,
  output logic [PC_W-1:0]        push_pc_o,
  output logic [1:0]             push_nbytes_o,
  output logic                   gie_clr_o,
  output logic                   core_rst_o
);

  logic [NVEC-1:0]  pend_w, elig_w, grant_w, svc_w;
  logic             any_w, flush_w;
  logic [VEC_W-1:0] idx_w;

  irq_pending_set #(.NVEC(NVEC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise_i (raise_i),
    .clear_i (clear_i),
    .svc_i   (svc_w),
    .flush_i (flush_w),
    .pend_o  (pend_w)
  );

  irq_wake_filter #(.NVEC(NVEC), .MODE_W(MODE_W)) u_wake (
    .pend_i     (pend_w),
    .sleeping_i (sleeping_i),
    .mode_i     (sleep_mode_i),
    .wake_cap_i (wake_cap_i),
    .elig_o     (elig_w)
  );

  irq_prio_pick #(.NVEC(NVEC)) u_pick (
    .req_i   (elig_w),
    .any_o   (any_w),
    .idx_o   (idx_w),
    .grant_o (grant_w)
  );

  irq_service_ctl #(.NVEC(NVEC), .PC_W(PC_W)) u_svc (
    .clk           (clk),
    .rst_n         (rst_n),
    .step_i        (step_done_i),
    .reti_i        (reti_i),
    .gie_i         (gie_i),
    .any_i         (any_w),
    .idx_i         (idx_w),
    .grant_i       (grant_w),
    .pc_i          (pc_i),
    .offset_i      (vec_offset_i),
    .pc3_i         (pc3_i),
    .svc_o         (svc_w),
    .flush_o       (flush_w),
    .take_o        (take_o),
    .new_pc_o      (new_pc_o),
    .push_o        (push_o),
    .push_pc_o     (push_pc_o),
    .push_nbytes_o (push_nbytes_o),
    .gie_clr_o     (gie_clr_o),
    .core_rst_o    (core_rst_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!take_o && !core_rst_o));

endmodule

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0]  raise_r = '0, clear_r = '0;
  logic         gie_r = 1'b0, slp_r = 1'b0, step_r = 1'b0, reti_r = 1'b0, p3_r = 1'b0;
  logic [7:0]   mode_r = '0;
  logic [255:0] wake_r = '0;
  logic [21:0]  pc_r = '0, off_r = '0;

  logic [255:0] nx_wake = '0;
  logic [21:0]  nx_pc = '0, nx_off = '0;
  logic         nx_p3 = 1'b0;

  logic         take_o, push_o, gie_clr_o, core_rst_o;
  logic [21:0]  new_pc_o, push_pc_o;
  logic [1:0]   push_nbytes_o;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_r), .clear_i(clear_r), .gie_i(gie_r),
    .sleeping_i(slp_r), .sleep_mode_i(mode_r), .wake_cap_i(wake_r),
    .step_done_i(step_r), .reti_i(reti_r), .pc_i(pc_r), .vec_offset_i(off_r),
    .pc3_i(p3_r), .take_o(take_o), .new_pc_o(new_pc_o), .push_o(push_o),
    .push_pc_o(push_pc_o), .push_nbytes_o(push_nbytes_o), .gie_clr_o(gie_clr_o),
    .core_rst_o(core_rst_o)
  );

  int    n_chk = 0, n_bad = 0;
  logic [31:0] m_pend = '0;
  logic  e_take = 1'b0, e_rst = 1'b0;
  logic [21:0] e_pc = '0, e_ppc = '0;
  logic [1:0]  e_nb = 2'd2;
  string e_tag = "R1";

  function automatic int pick(input logic [31:0] pend, input bit s, input logic [7:0] m,
                              input logic [255:0] w, output int count);
    int first;
    first = -1; count = 0;
    for (int i = 0; i < 32; i++) begin
      if (pend[i] && (!s || ((w[i*8 +: 8] & m) != 8'h00))) begin
        count++;
        if (first < 0) first = i;
      end
    end
    return first;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [31:0] r, input logic [31:0] c, input bit g, input bit s,
                     input logic [7:0] m, input bit st, input bit rt, input string tag);
    int idx, cnt;
    @(negedge clk);
    chk(e_tag, "take", 32'(take_o), 32'(e_take));
    chk(e_tag, "core_rst", 32'(core_rst_o), 32'(e_rst));
    chk(e_tag, "push", 32'(push_o), 32'(e_take));
    chk(e_tag, "gie_clr", 32'(gie_clr_o), 32'(e_take));
    if (e_take) begin
      chk(e_tag, "new_pc", 32'(new_pc_o), 32'(e_pc));
      chk(e_tag, "push_pc", 32'(push_pc_o), 32'(e_ppc));
      chk(e_tag, "push_nbytes", 32'(push_nbytes_o), 32'(e_nb));
    end
    // expectations for the edge that samples the inputs driven now
    idx = pick(m_pend, s, m, nx_wake, cnt);
    e_take = 1'b0; e_rst = 1'b0;
    if (st && !rt && idx >= 0) begin
      if (idx == 0) begin
        e_rst = 1'b1;
        m_pend = '0;
      end else if (g) begin
        e_take = 1'b1;
        e_pc   = nx_off + 22'(idx);
        e_ppc  = nx_pc;
        e_nb   = nx_p3 ? 2'd3 : 2'd2;
        m_pend = (m_pend & ~c & ~(32'd1 << idx)) | r;
      end else begin
        m_pend = (m_pend & ~c) | r;
      end
    end else begin
      m_pend = (m_pend & ~c) | r;
    end
    if (tag != "")                        e_tag = tag;
    else if (e_rst)                       e_tag = "R6";
    else if (e_take && cnt > 1)           e_tag = "R4";
    else if (e_take)                      e_tag = "R7";
    else if (st && rt)                    e_tag = "R9";
    else if (st && idx >= 0 && !g)        e_tag = "R8";
    else if (s)                           e_tag = "R5";
    else                                  e_tag = "R10";
    raise_r = r; clear_r = c; gie_r = g; slp_r = s; mode_r = m;
    step_r = st; reti_r = rt; pc_r = nx_pc; off_r = nx_off; p3_r = nx_p3; wake_r = nx_wake;
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] rr;
    void'($urandom(32'd24681));
    nx_wake[3*8 +: 8] = 8'h01;
    nx_wake[5*8 +: 8] = 8'h02;
    nx_wake[7*8 +: 8] = 8'h03;
    nx_pc = 22'h001234; nx_off = 22'h000040;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state checked on the first call
    cyc(32'h0, 0, 1, 0, 0, 0, 0, "R1");
    cyc(32'h0, 0, 1, 0, 0, 1, 0, "R1");      // nothing pending after reset
    // R2 / R4: raise 4 and 9, lowest first
    cyc((32'd1 << 4) | (32'd1 << 9), 0, 1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, 1, 0, "R4");
    cyc(0, 0, 1, 0, 0, 1, 0, "R4");
    cyc(0, 0, 1, 0, 0, 1, 0, "R2");
    // R2: duplicate raise gives one service
    cyc(32'd1 << 6, 0, 1, 0, 0, 0, 0, "R2");
    cyc(32'd1 << 6, 0, 1, 0, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, 1, 0, "R2");
    cyc(0, 0, 1, 0, 0, 1, 0, "R2");
    cyc(0, 0, 1, 0, 0, 0, 0, "R2");
    // R3: clear one of two; raise+clear same cycle keeps it
    cyc((32'd1 << 11) | (32'd1 << 12), 0, 1, 0, 0, 0, 0, "R3");
    cyc(0, 32'd1 << 11, 1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 1, 0, "R3");
    cyc(32'd1 << 13, 32'd1 << 13, 1, 0, 0, 0, 0, "R3");
    cyc(0, 0, 1, 0, 0, 1, 0, "R3");
    cyc(0, 0, 1, 0, 0, 1, 0, "R3");
    // R8: enable clear holds the request
    cyc(32'd1 << 8, 0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 1, 0, "R8");
    cyc(0, 0, 0, 0, 0, 1, 0, "R8");
    cyc(0, 0, 1, 0, 0, 1, 0, "R8");
    // R9: no check after return from interrupt
    cyc(32'd1 << 10, 0, 1, 0, 0, 0, 0, "R9");
    cyc(0, 0, 1, 0, 0, 1, 1, "R9");
    cyc(0, 0, 1, 0, 0, 1, 0, "R9");
    cyc(0, 0, 1, 0, 0, 0, 0, "R9");
    // R5: sleep masking by wake capability
    cyc((32'd1 << 3) | (32'd1 << 5) | (32'd1 << 9), 0, 1, 0, 0, 0, 0, "R5");
    cyc(0, 0, 1, 1, 8'h02, 1, 0, "R5");
    cyc(0, 0, 1, 1, 8'h04, 1, 0, "R5");
    cyc(0, 0, 1, 1, 8'h01, 1, 0, "R5");
    cyc(0, 0, 1, 0, 8'h00, 1, 0, "R5");
    cyc(0, 0, 1, 0, 0, 1, 0, "R5");
    // R7: three-byte push and offset wrap
    nx_p3 = 1'b1; nx_off = 22'h3FFFF0; nx_pc = 22'h2ABCDE;
    cyc(32'd1 << 20, 0, 1, 0, 0, 0, 0, "R7");
    cyc(0, 0, 1, 0, 0, 1, 0, "R7");
    nx_p3 = 1'b0;
    cyc(0, 0, 1, 0, 0, 0, 0, "R7");
    // R6: reset vector flushes everything, including a same-cycle raise
    cyc(32'h5, 0, 1, 0, 0, 0, 0, "R6");
    cyc(32'd1 << 7, 0, 1, 0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 0, 0, 1, 0, "R6");
    // R10: no step, no service
    cyc(32'd1 << 15, 0, 1, 0, 0, 0, 0, "R10");
    cyc(0, 0, 1, 0, 0, 0, 0, "R10");
    cyc(0, 0, 1, 0, 0, 0, 0, "R10");
    cyc(0, 0, 1, 0, 0, 1, 0, "R7");
    cyc(0, 0, 1, 0, 0, 0, 0, "R10");
    // random phase
    for (int k = 0; k < 8; k++) nx_wake[k*32 +: 32] = $urandom & $urandom;
    nx_off = 22'($urandom);
    for (int n = 0; n < 3000; n++) begin
      rr = $urandom & $urandom & $urandom & 32'hFFFF_FFFE;
      if ($urandom % 97 == 0) rr[0] = 1'b1;
      nx_pc = 22'($urandom);
      nx_p3 = 1'($urandom % 2);
      if ($urandom % 200 == 0) nx_off = 22'($urandom);
      cyc(rr, $urandom & $urandom & $urandom & $urandom, ($urandom % 4) != 0,
          ($urandom % 4) == 0, 8'($urandom), 1'($urandom % 2), ($urandom % 6) == 0, "");
    end
    cyc(0, 0, 0, 0, 0, 0, 0, "");
    finish_up();
  end

endmodule